// File: doc/BRIEF.md
# Four-Channel Dead-Time Pulse-Width Modulator

This block produces pulse-width modulated drive on four channels. Each channel has its own clock prescaler, period, duty value, polarity and dead time. Each channel drives a pair of complementary outputs: a high-side output and a low-side output. Each channel holds a reference level, and that level decides which side is active. A side turns on only after the reference has stayed on that side for a programmed number of prescaled ticks, so the two switches of a half-bridge are never on at the same time.

Software writes settings through one write strobe. The strobe carries a channel number, a field code and a data word. Period and duty writes go into shadow registers. The counter picks them up only at a period boundary or when the channel starts, so a waveform never mixes old and new values inside one period. Two bit-vector pulse inputs control the channels: one sets a channel's enable and the other clears it. A status vector reports which channels are enabled.

Each channel runs a three-state machine:
- `CH_IDLE`: the channel is stopped, its counter is held at zero and both outputs are off.
- `CH_LEAD`: the count is below the duty value.
- `CH_TRAIL`: the count is at or above the duty value.

The transitions are:
- start: `CH_IDLE` goes to `CH_LEAD` (or to `CH_TRAIL` when the duty is zero) on the first cycle the channel sees its enable.
- cross: `CH_LEAD` goes to `CH_TRAIL` on the tick where the count reaches the duty value.
- wrap: the machine goes back to `CH_LEAD` (or stays in `CH_TRAIL`) on the tick that ends the period.
- stop: any running state goes to `CH_IDLE` when the enable drops.

Top module: `quad_pwm_deadband`

## Requirements
- R1: The four channels run independently. A write with channel number c (`wr_ch`) changes only channel c, and channels enabled in the same cycle each follow their own settings.
- R2: Mode field (code 3) bits [2:0] hold s, and the channel counter then advances once every 2^s module clocks (s = 0..7, so divide-by-8 is s = 3).
- R3: With period value P (field code 0, P ≥ 1) the counter runs 0..P-1 and one period lasts P·2^s module clocks. The counter starts at 0 in the cycle after the status bit rises.
- R4: With polarity bit (mode bit 3) set to 1, the reference is high for the first D ticks of each period and low for the rest, where D is the duty value (field code 1). D = 0 keeps it low and D ≥ P keeps it high.
- R5: With polarity bit 0 the reference is inverted: it is low for the first D ticks and high for the rest.
- R6: Period and duty writes land in shadow registers. The active values are loaded from the shadows only when a channel starts and on the tick that ends a period, so a write made during a period first shapes the next period.
- R7: Field code 2 sets the dead time T in ticks. The high-side output is on while the reference is high and at least T ticks have passed since the reference last changed or the channel started. The low-side output follows the same rule with the reference low. The two outputs are never on together.
- R8: When T is greater than or equal to the length of a reference phase, the output of that phase stays off for the whole phase.
- R9: A 1 on a bit of `en_set` sets that channel's status bit at the next clock edge, and a 1 on `en_clr` clears it. If both are 1 for the same bit, clear wins.
- R10: While a channel's status bit is 0, both of its outputs are 0 and its counter is held at zero, so a re-enabled channel restarts its period from count 0. Dead time and mode (codes 2 and 3) take effect as soon as they are written and are meant to be written while the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel number of the write |
| wr_sel | input | 2 | Field code: 0 period, 1 duty, 2 dead time, 3 mode |
| wr_data | input | 16 | Write data |
| en_set | input | 4 | Write-one-to-set channel enables |
| en_clr | input | 4 | Write-one-to-clear channel enables |
| ch_status | output | 4 | Enabled channels |
| pwm_hi | output | 4 | High-side outputs, active high |
| pwm_lo | output | 4 | Low-side outputs, active high |

## Verification
The bench sweeps every prescale choice up to divide-by-4, periods of 1 to 5, and duty values from 0 to one past the period, with dead times of 0 to 3 and both polarities. It compares every output sample with an arithmetic model of the counter and the dead-time rule. These sweeps catch four kinds of error:
- a prescaler that is off by one, which would stretch or shrink each period;
- a compare that uses `<=` instead of `<`, which would make each pulse one tick too wide;
- a dead-time counter that does not restart at the period wrap, which would let outputs turn on early or overlap;
- a design that turns on an output inside a phase shorter than the dead time, which would produce a sliver pulse.

A period change and a duty change are written mid-period, and the bench checks that the old shape completes first; a design that loads the active registers at once would produce a malformed pulse. Other tests check that clear wins over set in the same cycle, and that two channels enabled together keep their separate settings.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    localparam int PSEL_W = 3;
    localparam int MODE_W = PSEL_W + 1;

    typedef enum logic [1:0] {
        FLD_PERIOD = 2'd0,
        FLD_DUTY   = 2'd1,
        FLD_DEAD   = 2'd2,
        FLD_MODE   = 2'd3
    } qpwm_field_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_LEAD  = 2'd1,
        CH_TRAIL = 2'd2
    } qpwm_state_e;

    typedef struct packed {
        logic              pol;
        logic [PSEL_W-1:0] psel;
    } qpwm_mode_t;

endpackage

// File: rtl/qpwm_prescale.sv
module qpwm_prescale
    import qpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    localparam int PCW = (1 << PSEL_W) - 1;
    localparam int SPW = PCW + 1;

    logic [PCW-1:0] div_cnt;
    logic [SPW-1:0] span;
    logic [PCW-1:0] limit;

    always_comb begin
        span  = SPW'(1) << sel;
        limit = PCW'(span - SPW'(1));
        tick  = run && (div_cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + PCW'(1);
        end
    end

    // R2: any divide above one leaves at least one idle cycle between ticks
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> !tick);

endmodule

// File: rtl/qpwm_deadband.sv
module qpwm_deadband #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           clear,
    input  logic [DTW-1:0] dead,
    output logic           settled
);
    logic [DTW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (clear) begin
            elapsed <= '0;
        end else if (tick && elapsed != '1) begin
            elapsed <= elapsed + DTW'(1);
        end
    end

    assign settled = (elapsed >= dead);

    // R7: the elapsed-tick count saturates instead of wrapping
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed == '1 && !clear) |=> elapsed == '1);

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
    import qpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_stb,
    input  qpwm_field_e   wr_fld,
    input  logic [CW-1:0] wr_data,
    output logic          hi,
    output logic          lo
);
    qpwm_state_e    state, state_nx;
    logic [CW-1:0]  per_sh, duty_sh, per_act, duty_act;
    logic [CW-1:0]  cnt, cnt_nx, duty_nx;
    logic [DTW-1:0] dead_q;
    qpwm_mode_t     mode_q;
    logic           tick, wrap, restart, flip, settled, ref_lvl, running;

    assign running = en && (state != CH_IDLE);
    assign restart = en && (state == CH_IDLE);

    qpwm_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .sel   (mode_q.psel),
        .tick  (tick)
    );

    always_comb begin
        wrap    = tick && (cnt == per_act - CW'(1));
        cnt_nx  = wrap ? '0 : cnt + CW'(1);
        duty_nx = wrap ? duty_sh : duty_act;
    end

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: begin
                if (en) state_nx = (duty_sh != '0) ? CH_LEAD : CH_TRAIL;
            end
            CH_LEAD, CH_TRAIL: begin
                if (!en)       state_nx = CH_IDLE;
                else if (tick) state_nx = (cnt_nx < duty_nx) ? CH_LEAD : CH_TRAIL;
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    assign flip = running && tick && (state_nx != state);

    qpwm_deadband #(.DTW(DTW)) u_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (restart || flip),
        .dead    (dead_q),
        .settled (settled)
    );

    // settings, shadows and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh   <= CW'(1);
            duty_sh  <= '0;
            per_act  <= CW'(1);
            duty_act <= '0;
            dead_q   <= '0;
            mode_q   <= '0;
            cnt      <= '0;
        end else begin
            if (wr_stb) begin
                unique case (wr_fld)
                    FLD_PERIOD: per_sh  <= wr_data;
                    FLD_DUTY:   duty_sh <= wr_data;
                    FLD_DEAD:   dead_q  <= wr_data[DTW-1:0];
                    FLD_MODE:   mode_q  <= qpwm_mode_t'(wr_data[MODE_W-1:0]);
                    default:    ;
                endcase
            end
            if (restart) begin
                per_act  <= per_sh;
                duty_act <= duty_sh;
                cnt      <= '0;
            end else if (!en) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt_nx;
                if (wrap) begin
                    per_act  <= per_sh;
                    duty_act <= duty_sh;
                end
            end
        end
    end

    // output process
    always_comb begin
        unique case (state)
            CH_LEAD:  ref_lvl = mode_q.pol;
            CH_TRAIL: ref_lvl = !mode_q.pol;
            default:  ref_lvl = 1'b0;
        endcase
        hi = running && settled && ref_lvl;
        lo = running && settled && !ref_lvl;
    end

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_IDLE && per_act != '0) |-> cnt < per_act);

    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(per_act) && $stable(duty_act)));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!hi && !lo));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE) |-> cnt == '0);

endmodule

// File: rtl/quad_pwm_deadband.sv
module quad_pwm_deadband
    import qpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] wr_ch,
    input  logic [1:0]             wr_sel,
    input  logic [CW-1:0]          wr_data,
    input  logic [NCH-1:0]         en_set,
    input  logic [NCH-1:0]         en_clr,
    output logic [NCH-1:0]         ch_status,
    output logic [NCH-1:0]         pwm_hi,
    output logic [NCH-1:0]         pwm_lo
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] en_q;
    qpwm_field_e    fld;

    assign fld = qpwm_field_e'(wr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | en_set) & ~en_clr;
    end

    assign ch_status = en_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qpwm_channel #(.CW(CW), .DTW(DTW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_q[i]),
            .wr_stb  (wr_en && (wr_ch == CHW'(i))),
            .wr_fld  (fld),
            .wr_data (wr_data),
            .hi      (pwm_hi[i]),
            .lo      (pwm_lo[i])
        );

        p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (en_set[i] && !en_clr[i]) |=> ch_status[i]);

        p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            en_clr[i] |=> !ch_status[i]);
    end

endmodule

// File: tb/quad_pwm_deadband_tb_top.sv
module quad_pwm_deadband_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  en_set = '0;
    logic [3:0]  en_clr = '0;
    logic [3:0]  ch_status, pwm_hi, pwm_lo;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    quad_pwm_deadband dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .en_set(en_set), .en_clr(en_clr),
        .ch_status(ch_status), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // {hi,lo} expected t module clocks after the start edge
    function automatic logic [1:0] exp_pair(input int t, input int p, input int d,
                                            input int dt, input int sel, input int pol);
        int  dv, k, m, el;
        bit  in_a, r;
        dv   = 1 << sel;
        k    = t / dv;
        m    = k % p;
        in_a = (m < d);
        r    = pol[0] ? in_a : !in_a;
        if (d == 0 || d >= p) el = k;
        else if (in_a)        el = m;
        else                  el = m - d;
        return {r && el >= dt, !r && el >= dt};
    endfunction

    task automatic wr(input int ch, input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic configure(input int ch, input int p, input int d, input int dt,
                             input int sel, input int pol);
        wr(ch, 0, p);
        wr(ch, 1, d);
        wr(ch, 2, dt);
        wr(ch, 3, (pol << 3) | sel);
    endtask

    task automatic stop_all();
        en_clr = 4'hF;
        @(negedge clk);
        en_clr = 4'h0;
        chk(ch_status == 4'h0, "R9 status after clear", ch_status, 0);
        chk(pwm_hi == 4'h0 && pwm_lo == 4'h0, "R10 outputs off when stopped",
            {pwm_hi, pwm_lo}, 0);
    endtask

    task automatic run_wave(input int ch, input int p, input int d, input int dt,
                            input int sel, input int pol);
        logic [1:0] e, a;
        int n;
        configure(ch, p, d, dt, sel, pol);
        @(negedge clk);
        en_set = 4'(1 << ch);
        @(negedge clk);
        en_set = 4'h0;
        chk(ch_status == 4'(1 << ch), "R9 status after set", ch_status, 1 << ch);
        @(negedge clk);
        n = 2 * p * (1 << sel) + 1;
        for (int t = 0; t < n; t++) begin
            e = exp_pair(t, p, d, dt, sel, pol);
            a = {pwm_hi[ch], pwm_lo[ch]};
            chk(a == e, pol ? "R2 R3 R4 R7 R8 waveform" : "R2 R3 R5 R7 R8 waveform",
                a, e);
            chk((pwm_hi & ~4'(1 << ch)) == 0 && (pwm_lo & ~4'(1 << ch)) == 0,
                "R1 R10 idle channels quiet", {pwm_hi, pwm_lo}, 0);
            @(negedge clk);
        end
        stop_all();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R9 run did not finish actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [1:0] e, a, e3, a3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ch_status == 4'h0, "R9 reset status", ch_status, 0);
        chk(pwm_hi == 4'h0 && pwm_lo == 4'h0, "R10 reset outputs", {pwm_hi, pwm_lo}, 0);

        // Sweep over small configurations, rotating channels
        begin
            int idx = 0;
            for (int sel = 0; sel < 3; sel++)
                for (int pol = 0; pol < 2; pol++)
                    for (int dt = 0; dt < 4; dt++)
                        for (int p = 1; p <= 5; p++)
                            for (int d = 0; d <= p + 1; d++) begin
                                run_wave(idx % 4, p, d, dt, sel, pol);
                                idx++;
                            end
        end

        // R6: mid-period update of duty and period on channel 2
        configure(2, 4, 1, 0, 0, 1);
        @(negedge clk);
        en_set = 4'b0100;
        @(negedge clk);
        en_set = 4'h0;
        @(negedge clk);
        for (int t = 0; t < 17; t++) begin
            e = (t < 4) ? exp_pair(t, 4, 1, 0, 0, 1) : exp_pair(t - 4, 6, 3, 0, 0, 1);
            a = {pwm_hi[2], pwm_lo[2]};
            chk(a == e, "R6 shadow transfer at wrap", a, e);
            wr_en = (t == 1 || t == 2);
            wr_ch = 2'd2;
            wr_sel = (t == 1) ? 2'd1 : 2'd0;
            wr_data = (t == 1) ? 16'd3 : 16'd6;
            @(negedge clk);
        end
        wr_en = 1'b0;
        stop_all();

        // R1: channels 0 and 3 started together with different settings
        configure(0, 3, 1, 1, 1, 1);
        configure(3, 5, 4, 0, 0, 0);
        @(negedge clk);
        en_set = 4'b1001;
        @(negedge clk);
        en_set = 4'h0;
        chk(ch_status == 4'b1001, "R9 two channels set", ch_status, 9);
        @(negedge clk);
        for (int t = 0; t < 30; t++) begin
            e  = exp_pair(t, 3, 1, 1, 1, 1);
            a  = {pwm_hi[0], pwm_lo[0]};
            e3 = exp_pair(t, 5, 4, 0, 0, 0);
            a3 = {pwm_hi[3], pwm_lo[3]};
            chk(a == e, "R1 channel 0 independent", a, e);
            chk(a3 == e3, "R1 channel 3 independent", a3, e3);
            @(negedge clk);
        end
        stop_all();

        // R9: set and clear in the same cycle, clear wins
        en_set = 4'b0010;
        en_clr = 4'b0010;
        @(negedge clk);
        en_set = 4'h0;
        en_clr = 4'h0;
        chk(ch_status == 4'h0, "R9 clear wins over set", ch_status, 0);
        @(negedge clk);
        chk(pwm_hi == 4'h0 && pwm_lo == 4'h0, "R10 no output after cancelled set",
            {pwm_hi, pwm_lo}, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule